// File: doc/BRIEF.md
# Interrupt Redirection Table with End-of-Interrupt Matching

This block holds a table of interrupt redirection entries and turns device interrupt lines into issued interrupts. Software reaches it through a small memory-mapped window. An 8-bit selector register picks one internal 32-bit word. A data register then reads or writes that word. Each of the 24 entries is 64 bits wide and sits at two selector values. Its low word carries the vector, the trigger mode, the mask and a read-only remote-pending flag.

Each input line belongs to one entry. An edge-triggered entry issues once for every rising edge. A level-triggered entry issues when its line is high and its remote-pending flag is clear, and the issue sets that flag. The handler finishes by writing a vector to the end-of-interrupt register. Every entry that holds that vector then drops its remote-pending flag in the same cycle. A line that is still high at that point issues again. Issued interrupts leave the block as one-cycle pulses carrying the vector and the entry number. A round-robin arbiter picks one request per cycle.

Top module: `irq_redir_top`

## Requirements
- R1: The selector register is at bus offset 00h and is 8 bits wide. It is written when byte lane 0 is enabled, reads back in bits 7:0 with zeros above, and resets to 00h.
- R2: The data register is at offset 10h. A write or read there counts only when all four byte enables are set. A write with fewer lanes leaves the selected word unchanged. A read with fewer lanes returns 0.
- R3: Entry n has its low word at selector 10h+2n and its high word at 10h+2n+1, for n from 0 to 23. After reset every low word reads 0001_0000h (masked) and every high word reads 0.
- R4: Low-word fields are: vector in bits 7:0, remote-pending in bit 14, trigger mode in bit 15 (1 = level, 0 = edge) and mask in bit 16 (1 = masked). Bit 14 is read-only: a write of 1 to it does not show in the read-back.
- R5: Selector 01h reads the constant 0017_0020h. Bits 23:16 hold the entry count minus one and bits 7:0 hold 20h. All other selectors below 10h, and all selectors from 40h to FFh, read 0. Writes through the data register to any of these selectors are ignored.
- R6: A write to offset 40h with lane 0 enabled is an end-of-interrupt. It clears the remote-pending bit of every entry whose vector equals written bits 7:0, all in the same cycle. Entries with other vectors keep their flag.
- R7: An unmasked level entry whose line is high and whose remote-pending bit is 0 issues once and sets remote-pending. It does not issue again while remote-pending stays set.
- R8: If a level line is still high when its remote-pending bit is cleared, the entry issues again.
- R9: An unmasked edge entry issues exactly once per rising edge of its line, however long the line stays high. It never sets remote-pending.
- R10: A masked entry never issues. A rising edge seen while an edge entry is masked is dropped and does not issue after unmasking.
- R11: An issue is a one-cycle int_valid pulse with int_vector and int_entry. When several entries request at once, the search starts at the entry after the last one issued, wrapping from 23 to 0. After reset, entry 0 is searched first.
- R12: bus_rdata is registered. It returns the read value in the cycle after the read request and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset (00h selector, 10h data, 40h end-of-interrupt) |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 24 | Interrupt lines, one per entry, synchronous to clk |
| int_valid | output | 1 | One-cycle issue pulse |
| int_vector | output | 8 | Vector of the issued entry |
| int_entry | output | 5 | Number of the issued entry |

## Verification
A remote-pending flag stuck at 1 shows up as a level line that stays silent after an end-of-interrupt. A flag stuck at 0 shows up as a second issue for the same entry within a few cycles. Both are visible on int_valid within about four cycles of the write or the line change. The flag is also visible on the next read of bit 14. A wrong round-robin pointer or a wrong edge-pending state changes the order or the count of issue pulses as soon as two lines rise together. A wrong selector or decode corrupts the next read-back, one cycle after the read request.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
    localparam int IRT_ENTRIES = 24;
    localparam int ENTRY_W     = $clog2(IRT_ENTRIES);
    localparam int VEC_W       = 8;

    localparam logic [7:0] OFS_INDEX = 8'h00;
    localparam logic [7:0] OFS_DATA  = 8'h10;
    localparam logic [7:0] OFS_EOI   = 8'h40;

    localparam logic [7:0] SEL_VERSION = 8'h01;
    localparam logic [7:0] SEL_TABLE   = 8'h10;
    localparam logic [7:0] SEL_RSVD    = 8'h40;

    localparam int BIT_RIRR  = 14;
    localparam int BIT_LEVEL = 15;
    localparam int BIT_MASK  = 16;

    localparam logic [31:0] LO_RESET = 32'h0001_0000;

    typedef struct packed {
        logic               valid;
        logic [VEC_W-1:0]   vector;
        logic [ENTRY_W-1:0] entry;
    } issue_t;

    function automatic logic [31:0] version_word(int n);
        return {8'h00, 8'(n - 1), 8'h00, 8'h20};
    endfunction
endpackage

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
    import irq_redir_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [31:0]      wdata,
    input  logic             eoi_stb,
    input  logic [VEC_W-1:0] eoi_vec,
    input  logic             irq,
    input  logic             grant,
    output logic             req,
    output logic [31:0]      rd_lo,
    output logic [31:0]      rd_hi,
    output logic [VEC_W-1:0] vector,
    output logic             level,
    output logic             rirr
);
    logic [31:0] lo_q, hi_q;
    logic        prev_q, pend_q, rirr_q;
    logic        masked, rise;

    assign masked = lo_q[BIT_MASK];
    assign level  = lo_q[BIT_LEVEL];
    assign vector = lo_q[VEC_W-1:0];
    assign rise   = irq & ~prev_q;
    assign rirr   = rirr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= LO_RESET;
            hi_q   <= '0;
            prev_q <= 1'b0;
            pend_q <= 1'b0;
            rirr_q <= 1'b0;
        end else begin
            prev_q <= irq;
            if (wr_lo) lo_q <= wdata & ~(32'h1 << BIT_RIRR);
            if (wr_hi) hi_q <= wdata;
            // edge capture: dropped while masked or in level mode
            if (masked || level) pend_q <= 1'b0;
            else                 pend_q <= rise | (pend_q & ~grant);
            if (grant && level)                      rirr_q <= 1'b1;
            else if (eoi_stb && (eoi_vec == vector)) rirr_q <= 1'b0;
        end
    end

    always_comb begin
        if (masked)     req = 1'b0;
        else if (level) req = irq & ~rirr_q;
        else            req = pend_q;
    end

    assign rd_lo = lo_q | (32'(rirr_q) << BIT_RIRR);
    assign rd_hi = hi_q;
endmodule

// File: rtl/irq_redir_rr.sv
module irq_redir_rr #(
    parameter int N  = 24,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic          any,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] last_q;

    always_comb begin
        any     = 1'b0;
        gnt     = '0;
        gnt_idx = '0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = int'(last_q) + k;
            if (c >= N) c = c - N;
            if (!any && req[c]) begin
                any     = 1'b1;
                gnt[c]  = 1'b1;
                gnt_idx = IW'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      last_q <= IW'(N - 1);
        else if (any) last_q <= gnt_idx;
    end
endmodule

// File: rtl/irq_redir_top.sv
module irq_redir_top
    import irq_redir_pkg::*;
#(
    parameter int N = IRT_ENTRIES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [7:0]         bus_addr,
    input  logic [3:0]         bus_be,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [N-1:0]       irq_in,
    output logic               int_valid,
    output logic [VEC_W-1:0]   int_vector,
    output logic [ENTRY_W-1:0] int_entry
);
    localparam logic [7:0] SEL_END = 8'(16 + 2 * N);

    logic full, wr_sel, wr_dat, eoi_stb, rd_any;
    logic [7:0] idx_q, tbl_off;
    logic in_tbl;
    logic [ENTRY_W-1:0] ent_sel;
    logic [31:0] win_data, rd_next, rdata_q;

    logic [N-1:0][31:0]      lo_a, hi_a;
    logic [N-1:0][VEC_W-1:0] vec_a;
    logic [N-1:0]            req_v, gnt_v, level_v, rirr_v;
    logic                    gnt_any;
    logic [ENTRY_W-1:0]      gnt_idx;
    issue_t                  iss_q;

    assign full    = (bus_be == 4'hF);
    assign wr_sel  = bus_sel &  bus_wr & (bus_addr == OFS_INDEX) & bus_be[0];
    assign wr_dat  = bus_sel &  bus_wr & (bus_addr == OFS_DATA) & full;
    assign eoi_stb = bus_sel &  bus_wr & (bus_addr == OFS_EOI) & bus_be[0];
    assign rd_any  = bus_sel & ~bus_wr;

    assign in_tbl  = (idx_q >= SEL_TABLE) && (idx_q < SEL_END);
    assign tbl_off = idx_q - SEL_TABLE;
    assign ent_sel = ENTRY_W'(tbl_off >> 1);

    always_ff @(posedge clk) begin
        if (rst)         idx_q <= '0;
        else if (wr_sel) idx_q <= bus_wdata[7:0];
    end

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic hit;
        assign hit = wr_dat & in_tbl & (ent_sel == ENTRY_W'(i));
        irq_redir_entry u_ent (
            .clk    (clk),
            .rst    (rst),
            .wr_lo  (hit & ~tbl_off[0]),
            .wr_hi  (hit &  tbl_off[0]),
            .wdata  (bus_wdata),
            .eoi_stb(eoi_stb),
            .eoi_vec(bus_wdata[VEC_W-1:0]),
            .irq    (irq_in[i]),
            .grant  (gnt_v[i]),
            .req    (req_v[i]),
            .rd_lo  (lo_a[i]),
            .rd_hi  (hi_a[i]),
            .vector (vec_a[i]),
            .level  (level_v[i]),
            .rirr   (rirr_v[i])
        );
    end

    irq_redir_rr #(.N(N), .IW(ENTRY_W)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .req    (req_v),
        .gnt    (gnt_v),
        .any    (gnt_any),
        .gnt_idx(gnt_idx)
    );

    always_comb begin
        if (in_tbl)                    win_data = tbl_off[0] ? hi_a[ent_sel] : lo_a[ent_sel];
        else if (idx_q == SEL_VERSION) win_data = version_word(N);
        else                           win_data = '0;
    end

    always_comb begin
        rd_next = '0;
        if (bus_addr == OFS_INDEX)           rd_next = {24'h0, idx_q};
        else if (bus_addr == OFS_DATA && full) rd_next = win_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            iss_q   <= '0;
        end else begin
            if (rd_any) rdata_q <= rd_next;
            iss_q.valid  <= gnt_any;
            iss_q.vector <= vec_a[gnt_idx];
            iss_q.entry  <= gnt_idx;
        end
    end

    assign bus_rdata  = rdata_q;
    assign int_valid  = iss_q.valid;
    assign int_vector = iss_q.vector;
    assign int_entry  = iss_q.entry;
endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk
    import irq_redir_pkg::*;
#(
    parameter int N = IRT_ENTRIES
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    bus_sel,
    input logic                    bus_wr,
    input logic [7:0]              bus_addr,
    input logic [3:0]              bus_be,
    input logic [31:0]             bus_rdata,
    input logic [7:0]              idx_q,
    input logic                    eoi_stb,
    input logic [VEC_W-1:0]        eoi_vec,
    input logic [N-1:0][VEC_W-1:0] vec_a,
    input logic [N-1:0]            level_v,
    input logic [N-1:0]            rirr_v,
    input logic                    int_valid,
    input logic [ENTRY_W-1:0]      int_entry
);
    // R1
    idx_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (idx_q == 8'h00));

    // R5
    reserved_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == OFS_DATA && bus_be == 4'hF && idx_q >= SEL_RSVD)
        |=> (bus_rdata == 32'h0));

    // R11
    entry_range_chk: assert property (@(posedge clk) disable iff (rst)
        int_valid |-> (int_entry < ENTRY_W'(N)));

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R6
        eoi_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (eoi_stb && rirr_v[i] && vec_a[i] == eoi_vec) |=> !rirr_v[i]);

        // R7
        rirr_set_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(rirr_v[i]) |-> (int_valid && int_entry == ENTRY_W'(i)));

        // R7
        rirr_block_chk: assert property (@(posedge clk) disable iff (rst)
            (int_valid && int_entry == ENTRY_W'(i) && $past(level_v[i])) |-> !$past(rirr_v[i]));
    end
endmodule

bind irq_redir_top irq_redir_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_be   (bus_be),
    .bus_rdata(bus_rdata),
    .idx_q    (idx_q),
    .eoi_stb  (eoi_stb),
    .eoi_vec  (bus_wdata[7:0]),
    .vec_a    (vec_a),
    .level_v  (level_v),
    .rirr_v   (rirr_v),
    .int_valid(int_valid),
    .int_entry(int_entry)
);

// File: tb/tb_irq_redir_top.sv
module tb_irq_redir_top;
    import irq_redir_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [23:0] irq_in = '0;
    logic        int_valid;
    logic [7:0]  int_vector;
    logic [4:0]  int_entry;

    int checks = 0, failures = 0, cycles = 0;
    int iss_n = 0;
    logic [7:0] log_vec [64];
    logic [4:0] log_ent [64];
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    irq_redir_top dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_in(irq_in), .int_valid(int_valid),
        .int_vector(int_vector), .int_entry(int_entry)
    );

    always @(negedge clk) begin
        if (!rst && int_valid && iss_n < 64) begin
            log_vec[iss_n] <= int_vector;
            log_ent[iss_n] <= int_entry;
            iss_n <= iss_n + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wr_word(input logic [7:0] sel, input logic [31:0] d);
        bus_write(OFS_INDEX, 4'h1, {24'h0, sel});
        bus_write(OFS_DATA, 4'hF, d);
    endtask

    task automatic rd_word(input logic [7:0] sel, output logic [31:0] d);
        bus_write(OFS_INDEX, 4'h1, {24'h0, sel});
        bus_read(OFS_DATA, 4'hF, d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // selector, write data, expected read-back
    localparam logic [71:0] TBL [9] = '{
        {8'h10, 32'h0000_A031, 32'h0000_A031},
        {8'h11, 32'hFF00_0000, 32'hFF00_0000},
        {8'h12, 32'h0001_4022, 32'h0001_0022},
        {8'h3E, 32'h0001_8055, 32'h0001_8055},
        {8'h3F, 32'h1234_5678, 32'h1234_5678},
        {8'h01, 32'hFFFF_FFFF, 32'h0017_0020},
        {8'h05, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'h40, 32'hFFFF_FFFF, 32'h0000_0000},
        {8'hFF, 32'h0000_00AA, 32'h0000_0000}
    };

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                failures++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] r;
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 R3 R11: reset state
        check("R11 idle after reset", {31'h0, int_valid}, 32'h0);
        bus_read(OFS_INDEX, 4'h1, r);
        check("R1 selector reset", r, 32'h0);
        rd_word(8'h10, r);
        check("R3 low word reset", r, 32'h0001_0000);
        rd_word(8'h3F, r);
        check("R3 high word reset", r, 32'h0);
        bus_read(OFS_INDEX, 4'h1, r);
        check("R1 selector read-back", r, 32'h0000_003F);

        // R3 R4 R5 R12: register table walk
        for (int i = 0; i < 9; i++) begin
            wr_word(TBL[i][71:64], TBL[i][63:32]);
            rd_word(TBL[i][71:64], r);
            check($sformatf("R12 R3 R4 R5 table row %0d", i), r, TBL[i][31:0]);
        end
        check("R12 read data held", bus_rdata, 32'h0);

        // R2: narrow accesses to data register
        wr_word(8'h13, 32'h0000_00AA);
        bus_write(OFS_DATA, 4'h3, 32'h0000_0055);
        bus_read(OFS_DATA, 4'hF, r);
        check("R2 narrow write ignored", r, 32'h0000_00AA);
        bus_read(OFS_DATA, 4'h1, r);
        check("R2 narrow read zero", r, 32'h0);

        // R7: level issue sets remote-pending and blocks reissue
        wr_word(8'h14, 32'h0000_8041);
        base = iss_n;
        @(negedge clk); irq_in[2] = 1'b1;
        idle(6);
        check("R7 one level issue", iss_n - base, 1);
        check("R7 issued vector", {24'h0, log_vec[base]}, 32'h41);
        check("R7 issued entry", {27'h0, log_ent[base]}, 32'd2);
        rd_word(8'h14, r);
        check("R7 R4 remote-pending visible", r, 32'h0000_C041);
        idle(5);
        check("R7 no reissue while pending", iss_n - base, 1);

        // R8: line still high at end-of-interrupt
        base = iss_n;
        bus_write(OFS_EOI, 4'h1, 32'h41);
        idle(5);
        check("R8 reissue after eoi", iss_n - base, 1);
        @(negedge clk); irq_in[2] = 1'b0;
        bus_write(OFS_EOI, 4'h1, 32'h41);
        idle(4);
        rd_word(8'h14, r);
        check("R6 pending cleared", r, 32'h0000_8041);
        check("R8 no issue with line low", iss_n - base, 1);

        // R6 R11: shared vectors, simultaneous requests
        wr_word(8'h16, 32'h0000_8050);
        wr_word(8'h18, 32'h0000_8050);
        wr_word(8'h1A, 32'h0000_8051);
        base = iss_n;
        @(negedge clk); irq_in[5:3] = 3'b111;
        idle(7);
        check("R11 three issues", iss_n - base, 3);
        check("R11 order first", {27'h0, log_ent[base]}, 32'd3);
        check("R11 order second", {27'h0, log_ent[base+1]}, 32'd4);
        check("R11 order third", {27'h0, log_ent[base+2]}, 32'd5);
        @(negedge clk); irq_in[4:3] = 2'b00;
        bus_write(OFS_EOI, 4'h1, 32'h50);
        rd_word(8'h16, r);
        check("R6 entry 3 cleared", r, 32'h0000_8050);
        rd_word(8'h18, r);
        check("R6 entry 4 cleared", r, 32'h0000_8050);
        rd_word(8'h1A, r);
        check("R6 other vector kept", r, 32'h0000_C051);
        check("R6 no issue after eoi", iss_n - base, 3);

        // R9: edge entry
        wr_word(8'h1C, 32'h0000_0060);
        base = iss_n;
        @(negedge clk); irq_in[6] = 1'b1;
        idle(8);
        check("R9 one issue per edge", iss_n - base, 1);
        check("R9 edge vector", {24'h0, log_vec[base]}, 32'h60);
        rd_word(8'h1C, r);
        check("R9 no remote-pending", r, 32'h0000_0060);
        @(negedge clk); irq_in[6] = 1'b0;
        idle(2);
        irq_in[6] = 1'b1;
        idle(6);
        check("R9 second edge issues", iss_n - base, 2);

        // R10: masking
        wr_word(8'h1E, 32'h0001_8070);
        base = iss_n;
        @(negedge clk); irq_in[7] = 1'b1;
        idle(8);
        check("R10 masked level silent", iss_n - base, 0);
        wr_word(8'h1E, 32'h0000_8070);
        idle(5);
        check("R10 unmask issues", iss_n - base, 1);
        check("R10 unmasked entry", {27'h0, log_ent[base]}, 32'd7);
        wr_word(8'h20, 32'h0001_0080);
        base = iss_n;
        @(negedge clk); irq_in[8] = 1'b1;
        idle(3);
        wr_word(8'h20, 32'h0000_0080);
        idle(6);
        check("R10 masked edge dropped", iss_n - base, 0);

        // R11: wrap-around of the search start (last issued entry 7)
        wr_word(8'h10, 32'h0000_0090);
        wr_word(8'h3E, 32'h0000_0097);
        base = iss_n;
        @(negedge clk); irq_in[0] = 1'b1; irq_in[23] = 1'b1;
        idle(6);
        check("R11 wrap two issues", iss_n - base, 2);
        check("R11 wrap first entry 23", {27'h0, log_ent[base]}, 32'd23);
        check("R11 wrap second entry 0", {27'h0, log_ent[base+1]}, 32'd0);
        check("R11 wrap vector", {24'h0, log_vec[base+1]}, 32'h90);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule